// File: doc/BRIEF.md
# Integer ALU Stage with Carry, Overflow and Condition Flags

A purely combinational 64-bit integer execution stage for a pipelined processor. One operand pair, a carry input and an operation context enter the stage. In the same cycle it returns a result together with a 64-bit and a 32-bit carry, a 64-bit and a 32-bit overflow, and a four-bit condition field. Each of these outputs carries its own write-valid flag, which tells the writeback logic whether that output must be committed for the current operation.

The stage implements four operations:

- add with carry;
- sign extension from 1, 2 or 4 bytes;
- a compare-style sum, which consumes no carry;
- a byte-equality search of one byte of A against every byte of B.

The operation code, data length, 32-bit-mode flag, routing tag and summary-overflow bit all pass through unchanged, so later stages see the same context. In 32-bit mode the upstream stages are expected to supply operands whose upper halves are zero.

Top module: `alu_stage`

## Requirements
- R1: With op code 0 (add), {ca_o[0], res_o} equals the 65-bit sum A + B + ca_i[0], and res_ok_o, ca_ok_o and ov_ok_o are 1 while cr_ok_o is 0.
- R2: With op code 0, ca_o[1] (the 32-bit carry) equals bit 32 of A[31:0] + B[31:0] + ca_i[0].
- R3: With op code 0, ov_o[0] = (ca_o[0] ^ res_o[63]) & ~(A[63] ^ B[63]), and ov_o[1] = (ca_o[1] ^ res_o[31]) & ~(A[31] ^ B[31]).
- R4: With op code 1 (sign extension) and len_i of 1, 2 or 4, the low 8·len_i bits of res_o copy A and every higher bit repeats A bit 8·len_i−1. Any other len_i gives res_o = A. Only res_ok_o is 1, and ca_o, ov_o and cr_o are 0.
- R5: With op code 2 (compare), res_o equals the low 64 bits of A + B whatever ca_i holds. All four valid flags are 0, and ca_o, ov_o and cr_o are 0.
- R6: With op code 3 (byte search), cr_o bit 2 is 1 exactly when A[7:0] equals at least one of the eight bytes of B, and the other cr_o bits are 0. Only cr_ok_o is 1, and res_o, ca_o and ov_o are 0.
- R7: op_o, len_o, w32_o, tag_o and so_o always equal op_i, len_i, w32_i, tag_i and so_i.
- R8: Op codes 4 to 7 drive res_o, ca_o, ov_o and cr_o to 0 and all four valid flags to 0.
- R9: ca_i[1] (the incoming 32-bit carry) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ina_i | input | 64 | Operand A |
| inb_i | input | 64 | Operand B |
| ca_i | input | 2 | Carry in: bit 0 is the 64-bit carry, bit 1 the 32-bit carry (unused) |
| so_i | input | 1 | Summary-overflow in |
| op_i | input | 3 | Operation code: 0 add, 1 sign extend, 2 compare, 3 byte search |
| len_i | input | 4 | Data length in bytes |
| w32_i | input | 1 | 32-bit-mode flag |
| tag_i | input | 2 | Routing tag |
| res_o | output | 64 | Result |
| res_ok_o | output | 1 | Result write-valid |
| ca_o | output | 2 | Carry out: bit 0 64-bit, bit 1 32-bit |
| ca_ok_o | output | 1 | Carry write-valid |
| ov_o | output | 2 | Overflow out: bit 0 64-bit, bit 1 32-bit |
| ov_ok_o | output | 1 | Overflow write-valid |
| cr_o | output | 4 | Condition field; bit 2 is the byte-match flag |
| cr_ok_o | output | 1 | Condition-field write-valid |
| so_o | output | 1 | Summary-overflow out |
| op_o | output | 3 | Operation code out |
| len_o | output | 4 | Data length out |
| w32_o | output | 1 | 32-bit-mode flag out |
| tag_o | output | 2 | Routing tag out |

## Verification
The bound checker re-derives, on every input change, the following properties:

- the 65-bit add identity, the 32-bit carry and both overflow formulas;
- the byte-match flag;
- the context pass-through;
- the all-quiet output for unused op codes;
- the rule that at most the flags named for the operation are set.

Only the bench's scenarios can show the remaining behaviour. These are the sign-extension replication for each data length, including lengths that fall back to copying A, and the fact that compare ignores the carry. They also cover the fact that the incoming 32-bit carry changes nothing, which the bench shows by applying both values to the same operands.

// File: rtl/alu_stage_pkg.sv
package alu_stage_pkg;
  localparam int OPW       = 3;
  localparam int LENW      = 4;
  localparam int CRW       = 4;
  localparam int CR_EQ_BIT = 2;

  typedef enum logic [OPW-1:0] {
    ALU_ADD  = 3'd0,
    ALU_SEXT = 3'd1,
    ALU_CMP  = 3'd2,
    ALU_BEQ  = 3'd3
  } alu_op_e;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          c_full,
  output logic          c_half,
  output logic          v_full,
  output logic          v_half
);
  localparam int HW = DW / 2;

  logic [DW:0] wide;
  logic [HW:0] half;

  assign wide   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  assign half   = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
  assign sum    = wide[DW-1:0];
  assign c_full = wide[DW];
  assign c_half = half[HW];
  assign v_full = (c_full ^ sum[DW-1]) & ~(a[DW-1] ^ b[DW-1]);
  assign v_half = (c_half ^ sum[HW-1]) & ~(a[HW-1] ^ b[HW-1]);
endmodule

// File: rtl/alu_sext.sv
module alu_sext
  import alu_stage_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0]   a,
  input  logic [LENW-1:0] len,
  output logic [DW-1:0]   y
);
  localparam int NEXT = $clog2(DW / 8);

  logic [DW-1:0] ext [NEXT];

  for (genvar k = 0; k < NEXT; k++) begin : g_len
    localparam int W = 8 << k;
    assign ext[k] = {{(DW-W){a[W-1]}}, a[W-1:0]};
  end

  always_comb begin
    y = a;
    for (int k = 0; k < NEXT; k++) begin
      if (len == LENW'(1 << k)) y = ext[k];
    end
  end
endmodule

// File: rtl/alu_bytefind.sv
module alu_bytefind #(
  parameter int DW = 64
) (
  input  logic [7:0]    key,
  input  logic [DW-1:0] b,
  output logic          hit
);
  localparam int NB = DW / 8;

  logic [NB-1:0] match;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign match[i] = (b[8*i +: 8] == key);
  end

  assign hit = |match;
endmodule

// File: rtl/alu_stage.sv
module alu_stage
  import alu_stage_pkg::*;
#(
  parameter int DW    = 64,
  parameter int TAG_W = 2
) (
  input  logic [DW-1:0]    ina_i,
  input  logic [DW-1:0]    inb_i,
  input  logic [1:0]       ca_i,
  input  logic             so_i,
  input  logic [OPW-1:0]   op_i,
  input  logic [LENW-1:0]  len_i,
  input  logic             w32_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [DW-1:0]    res_o,
  output logic             res_ok_o,
  output logic [1:0]       ca_o,
  output logic             ca_ok_o,
  output logic [1:0]       ov_o,
  output logic             ov_ok_o,
  output logic [CRW-1:0]   cr_o,
  output logic             cr_ok_o,
  output logic             so_o,
  output logic [OPW-1:0]   op_o,
  output logic [LENW-1:0]  len_o,
  output logic             w32_o,
  output logic [TAG_W-1:0] tag_o
);
  logic          add_cin;
  logic [DW-1:0] add_sum;
  logic          c_full, c_half, v_full, v_half;
  logic [DW-1:0] sext_y;
  logic          byte_hit;
  logic          unused_ca32;

  // the incoming 32-bit carry is not consumed by this stage
  assign unused_ca32 = ca_i[1];

  // compare takes no carry; only add feeds ca_i[0] into the adder
  assign add_cin = (op_i == ALU_ADD) & ca_i[0];

  alu_adder #(.DW(DW)) u_add (
    .a      (ina_i),
    .b      (inb_i),
    .cin    (add_cin),
    .sum    (add_sum),
    .c_full (c_full),
    .c_half (c_half),
    .v_full (v_full),
    .v_half (v_half)
  );

  alu_sext #(.DW(DW)) u_sext (
    .a   (ina_i),
    .len (len_i),
    .y   (sext_y)
  );

  alu_bytefind #(.DW(DW)) u_find (
    .key (ina_i[7:0]),
    .b   (inb_i),
    .hit (byte_hit)
  );

  always_comb begin
    res_o    = '0;
    res_ok_o = 1'b0;
    ca_o     = '0;
    ca_ok_o  = 1'b0;
    ov_o     = '0;
    ov_ok_o  = 1'b0;
    cr_o     = '0;
    cr_ok_o  = 1'b0;
    case (op_i)
      ALU_ADD: begin
        res_o    = add_sum;
        ca_o     = {c_half, c_full};
        ov_o     = {v_half, v_full};
        res_ok_o = 1'b1;
        ca_ok_o  = 1'b1;
        ov_ok_o  = 1'b1;
      end
      ALU_SEXT: begin
        res_o    = sext_y;
        res_ok_o = 1'b1;
      end
      ALU_CMP: begin
        res_o = add_sum;
      end
      ALU_BEQ: begin
        cr_o[CR_EQ_BIT] = byte_hit;
        cr_ok_o         = 1'b1;
      end
      default: ;
    endcase
  end

  assign so_o  = so_i;
  assign op_o  = op_i;
  assign len_o = len_i;
  assign w32_o = w32_i;
  assign tag_o = tag_i;
endmodule

// File: rtl/alu_stage_chk.sv
module alu_stage_chk
  import alu_stage_pkg::*;
#(
  parameter int DW    = 64,
  parameter int TAG_W = 2
) (
  input logic [DW-1:0]    ina_i,
  input logic [DW-1:0]    inb_i,
  input logic [1:0]       ca_i,
  input logic             so_i,
  input logic [OPW-1:0]   op_i,
  input logic [LENW-1:0]  len_i,
  input logic             w32_i,
  input logic [TAG_W-1:0] tag_i,
  input logic [DW-1:0]    res_o,
  input logic             res_ok_o,
  input logic [1:0]       ca_o,
  input logic             ca_ok_o,
  input logic [1:0]       ov_o,
  input logic             ov_ok_o,
  input logic [CRW-1:0]   cr_o,
  input logic             cr_ok_o,
  input logic             so_o,
  input logic [OPW-1:0]   op_o,
  input logic [LENW-1:0]  len_o,
  input logic             w32_o,
  input logic [TAG_W-1:0] tag_o
);
  localparam int HW = DW / 2;

  logic          known;
  logic [DW:0]   ref_sum;
  logic [HW:0]   ref_half;
  logic          ref_hit;

  assign known = !$isunknown({ina_i, inb_i, ca_i, so_i, op_i, len_i, w32_i, tag_i});
  assign ref_sum  = {1'b0, ina_i} + {1'b0, inb_i} + {{DW{1'b0}}, ca_i[0]};
  assign ref_half = {1'b0, ina_i[HW-1:0]} + {1'b0, inb_i[HW-1:0]} + {{HW{1'b0}}, ca_i[0]};

  always_comb begin
    ref_hit = 1'b0;
    for (int i = 0; i < DW / 8; i++) begin
      if (inb_i[8*i +: 8] == ina_i[7:0]) ref_hit = 1'b1;
    end
  end

  always_comb begin
    if (known) begin
      if (op_i == ALU_ADD) begin
        assert_add_sum_R1: assert ({ca_o[0], res_o} == ref_sum && res_ok_o && ca_ok_o && ov_ok_o && !cr_ok_o);
        assert_add_ca32_R2: assert (ca_o[1] == ref_half[HW]);
        assert_add_ov_R3: assert (ov_o[0] == ((ca_o[0] ^ res_o[DW-1]) & ~(ina_i[DW-1] ^ inb_i[DW-1]))
                                  && ov_o[1] == ((ca_o[1] ^ res_o[HW-1]) & ~(ina_i[HW-1] ^ inb_i[HW-1])));
      end
      if (op_i == ALU_BEQ) begin
        assert_byte_hit_R6: assert (cr_o == (CRW'(ref_hit) << CR_EQ_BIT) && cr_ok_o
                                    && !res_ok_o && !ca_ok_o && !ov_ok_o);
      end
      if (op_i > ALU_BEQ) begin
        assert_quiet_code_R8: assert (res_o == '0 && ca_o == '0 && ov_o == '0 && cr_o == '0
                                      && !res_ok_o && !ca_ok_o && !ov_ok_o && !cr_ok_o);
      end
      // R5: compare never asks for any writeback
      assert_flags_R5: assert (op_i != ALU_CMP || {res_ok_o, ca_ok_o, ov_ok_o, cr_ok_o} == 4'b0);
      assert_pass_R7: assert (op_o == op_i && len_o == len_i && w32_o == w32_i
                              && tag_o == tag_i && so_o == so_i);
    end
  end
endmodule

bind alu_stage alu_stage_chk #(.DW(DW), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/alu_stage_test.sv
module alu_stage_test;
  localparam int DW = 64;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [DW-1:0] a, b, res;
  logic [1:0]    ca_in, ca, ov;
  logic          so_in, w32, res_ok, ca_ok, ov_ok, cr_ok, so;
  logic [2:0]    op, op_q;
  logic [3:0]    len, len_q, cr;
  logic          w32_q;
  logic [TW-1:0] tag, tag_q;

  alu_stage #(.DW(DW), .TAG_W(TW)) uut (
    .ina_i(a), .inb_i(b), .ca_i(ca_in), .so_i(so_in), .op_i(op), .len_i(len),
    .w32_i(w32), .tag_i(tag), .res_o(res), .res_ok_o(res_ok), .ca_o(ca),
    .ca_ok_o(ca_ok), .ov_o(ov), .ov_ok_o(ov_ok), .cr_o(cr), .cr_ok_o(cr_ok),
    .so_o(so), .op_o(op_q), .len_o(len_q), .w32_o(w32_q), .tag_o(tag_q)
  );

  int total = 0;
  int bad   = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] x = s;
    x ^= x << 13; x ^= x >> 7; x ^= x << 17;
    return x;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s op=%0d actual=%h expected=%h", req, op, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [3:0] l, input logic [63:0] x,
                       input logic [63:0] y, input logic [1:0] c, input logic s,
                       input logic w, input logic [TW-1:0] t);
    @(negedge clk);
    op = o; len = l; a = x; b = y; ca_in = c; so_in = s; w32 = w; tag = t;
    #1;
  endtask

  task automatic expect_all;
    logic [64:0] s65;
    logic [32:0] s33;
    logic [63:0] er;
    logic [1:0]  ec, eo;
    logic [3:0]  ecr, eok;
    logic        hit;
    s65 = {1'b0, a} + {1'b0, b} + {64'd0, ca_in[0]};
    s33 = {1'b0, a[31:0]} + {1'b0, b[31:0]} + {32'd0, ca_in[0]};
    er = '0; ec = '0; eo = '0; ecr = '0; eok = '0;
    case (op)
      3'd0: begin
        er = s65[63:0];
        ec = {s33[32], s65[64]};
        eo = {(s33[32] ^ er[31]) & ~(a[31] ^ b[31]), (s65[64] ^ er[63]) & ~(a[63] ^ b[63])};
        eok = 4'b1110;
      end
      3'd1: begin
        if (len == 1 || len == 2 || len == 4) begin
          for (int i = 0; i < 64; i++) er[i] = (i < 8*len) ? a[i] : a[8*len-1];
        end else er = a;
        eok = 4'b1000;
      end
      3'd2: er = a + b;
      3'd3: begin
        hit = 1'b0;
        for (int i = 0; i < 8; i++) if (b[8*i +: 8] == a[7:0]) hit = 1'b1;
        ecr = {1'b0, hit, 2'b00};
        eok = 4'b0001;
      end
      default: ;
    endcase
    case (op)
      3'd0: begin
        chk("R1 sum", {63'd0, ca[0], res}, {63'd0, s65});
        chk("R2 ca32", {127'd0, ca[1]}, {127'd0, ec[1]});
        chk("R3 ov", {126'd0, ov}, {126'd0, eo});
        chk("R1 flags", {124'd0, res_ok, ca_ok, ov_ok, cr_ok}, {124'd0, eok});
      end
      3'd1: chk("R4 sext", {60'd0, res_ok, ca_ok, ov_ok, cr_ok, ca, ov, cr, res},
                {60'd0, eok, 8'd0, er});
      3'd2: chk("R5 cmp", {60'd0, res_ok, ca_ok, ov_ok, cr_ok, ca, ov, cr, res},
                {60'd0, eok, 8'd0, er});
      3'd3: chk("R6 bytefind", {60'd0, res_ok, ca_ok, ov_ok, cr_ok, ca, ov, cr, res},
                {60'd0, eok, 4'd0, ecr, 64'd0});
      default: chk("R8 quiet", {60'd0, res_ok, ca_ok, ov_ok, cr_ok, ca, ov, cr, res}, 128'd0);
    endcase
    chk("R7 pass", {117'd0, op_q, len_q, w32_q, tag_q, so}, {117'd0, op, len, w32, tag, so_in});
  endtask

  task automatic rand_vec(input logic [2:0] o, input logic [3:0] l);
    logic [63:0] x, y;
    logic w;
    seed = nxt(seed); x = seed;
    seed = nxt(seed); y = seed;
    w = seed[5];
    if (seed[9:8] == 2'b00) y[8*seed[12:10] +: 8] = x[7:0];
    if (w) begin x[63:32] = '0; y[63:32] = '0; end
    drive(o, l, x, y, seed[21:20], seed[30], w, seed[41:40]);
    expect_all();
  endtask

  initial begin
    fork
      begin
        // idle state under reset: zero operands, add
        drive(3'd0, 4'd0, 64'd0, 64'd0, 2'b00, 1'b0, 1'b0, '0);
        chk("R1 idle", {124'd0, res_ok, ca_ok, ov_ok, cr_ok, res}, {124'd0, 4'b1110, 64'd0});
        rst_n = 1'b1;
        // add corners
        drive(3'd0, 4'd0, '1, 64'd0, 2'b01, 1'b0, 1'b0, '0); expect_all();
        drive(3'd0, 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 2'b00, 1'b1, 1'b0, 2'd3); expect_all();
        drive(3'd0, 4'd0, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 2'b00, 1'b0, 1'b0, 2'd1); expect_all();
        drive(3'd0, 4'd0, 64'h0000_0000_FFFF_FFFF, 64'd0, 2'b01, 1'b0, 1'b1, 2'd2); expect_all();
        drive(3'd0, 4'd0, 64'h0000_0000_7FFF_FFFF, 64'd0, 2'b01, 1'b0, 1'b1, 2'd0); expect_all();
        // R9: incoming 32-bit carry changes nothing
        for (int k = 0; k < 40; k++) begin
          logic [63:0] x, y, r0;
          logic [1:0] c0, v0;
          logic [2:0] o;
          seed = nxt(seed); x = seed; seed = nxt(seed); y = seed;
          o = 3'(k % 4);
          drive(o, 4'd2, x, y, 2'b01, 1'b0, 1'b0, '0);
          r0 = res; c0 = ca; v0 = ov;
          drive(o, 4'd2, x, y, 2'b11, 1'b0, 1'b0, '0);
          chk("R9 ca32 in ignored", {60'd0, ca, ov, res}, {60'd0, c0, v0, r0});
        end
        // R5: carry ignored by compare
        drive(3'd2, 4'd0, '1, 64'd1, 2'b11, 1'b0, 1'b0, '0); expect_all();
        drive(3'd2, 4'd0, 64'd5, 64'd7, 2'b01, 1'b1, 1'b0, '0); expect_all();
        // R4: sign extension over every length with both sign polarities
        for (int l = 0; l < 16; l++) begin
          drive(3'd1, 4'(l), 64'h0123_4567_89AB_CDEF, 64'd0, 2'b00, 1'b0, 1'b0, '0); expect_all();
          drive(3'd1, 4'(l), 64'hFEDC_BA98_7654_3210, 64'd0, 2'b00, 1'b0, 1'b0, '0); expect_all();
          drive(3'd1, 4'(l), 64'h0000_0000_8080_8080, 64'd0, 2'b00, 1'b0, 1'b1, '0); expect_all();
          for (int r = 0; r < 20; r++) rand_vec(3'd1, 4'(l));
        end
        // R6: match in each byte position and no match
        for (int p = 0; p < 8; p++) begin
          logic [63:0] y;
          y = 64'h1111_1111_1111_1111;
          y[8*p +: 8] = 8'hA5;
          drive(3'd3, 4'd0, 64'h0000_0000_0000_00A5, y, 2'b00, 1'b0, 1'b0, '0); expect_all();
        end
        drive(3'd3, 4'd0, 64'h22, 64'h1111_1111_1111_1111, 2'b01, 1'b0, 1'b0, '0); expect_all();
        // sweep every op code, including unused 4..7 (R8)
        for (int o = 0; o < 8; o++)
          for (int r = 0; r < 300; r++) rand_vec(3'(o), 4'(r % 16));
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule